// File: doc/BRIEF.md
# Serial Wire Link Reset and Protocol Select Watcher

This block sits on the target side of a shared debug data/mode pin and runs on the debug clock. It samples the pin once per rising edge and follows what the host does on the line. It counts runs of ones to spot line resets. It captures the 16-bit selection word that asks the port to leave JTAG operation for the two-wire serial protocol. It then decides when the line is aligned and ready for serial packets. Packet decoding and the JTAG TAP controller live elsewhere. The watcher only tells them whether serial mode is active.

A switch is accepted only after the full sequence has been seen: a line reset, then one of the two accepted selection words, then a second line reset. Both the current word and the older legacy word are accepted. After the second reset, the block waits for at least two idle (zero) cycles and then reports the link as ready. It also raises a flag saying that an identification-code read is owed. The packet decoder drops that flag by pulsing `idcode_done` once the first valid IDCODE read has completed. Any later line reset raises the flag again.

The state machine has six states:

- `ST_HUNT`: JTAG mode, waiting for a line reset.
- `ST_ARMED`: a line reset has been seen and extra ones are being absorbed.
- `ST_MATCH`: the selection word is being captured.
- `ST_SEAL`: the word matched and the second line reset is awaited.
- `ST_IDLE`: serial mode, counting idle zeros.
- `ST_READY`: serial mode, packets allowed.

Its transitions are:

- HUNT to ARMED on a line reset.
- ARMED to MATCH on the first zero, which is the first bit of the word.
- MATCH to SEAL on the sixteenth bit when the word matches.
- MATCH to HUNT on the sixteenth bit when it does not.
- SEAL to IDLE on a line reset.
- IDLE to READY on the second consecutive zero.
- READY to IDLE on a line reset.
- IDLE stays in IDLE on a line reset, with its idle count cleared.

Top module: `link_mode_watcher`

## Requirements
- R1: While reset is asserted and at the first clock after release, `lr_pulse`, `sw_mode`, `need_idcode` and `pkt_ready` are all 0.
- R2: `lr_pulse` is high for exactly one cycle after the edge that samples the 50th consecutive 1 on `line_in`. Further ones give no second pulse until a 0 has been sampled. A run of 49 ones ended by a 0 gives no pulse.
- R3: `sw_mode` rises only after the edge of the line reset that follows a matched selection word. Once high, it stays high until reset.
- R4: The selection word 16'h79E7, sent MSB first (bit 15 first), is accepted.
- R5: The legacy selection word 16'h6DB7, sent MSB first (byte 0x6D, then byte 0xB7), is accepted.
- R6: Ones that follow a line reset are ignored. Word capture begins at the first 0 sampled after the reset.
- R7: A captured word that matches neither pattern returns the watcher to waiting for a line reset. A line reset that follows a bad word does not enable serial mode.
- R8: A valid selection word that is not preceded by a line reset does not start a switch.
- R9: `need_idcode` goes to 1 together with any line reset while in serial mode, including the reset that enters serial mode. `idcode_done` clears it one cycle later. A line reset wins over `idcode_done` in the same cycle. In JTAG mode `need_idcode` stays 0 whatever `idcode_done` does.
- R10: `pkt_ready` rises after the edge that samples the second consecutive 0 following a line reset in serial mode. A 1 between those zeros restarts the count. Any line reset drops `pkt_ready` with the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug clock; the pin is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Sampled value of the shared data/mode pin |
| idcode_done | input | 1 | One-cycle strobe from the packet decoder after a valid IDCODE read |
| lr_pulse | output | 1 | One-cycle pulse after a line reset is recognised |
| sw_mode | output | 1 | Serial-wire protocol selected |
| need_idcode | output | 1 | An IDCODE read is still owed for alignment |
| pkt_ready | output | 1 | Idle requirement met; packets may follow |

## Verification
All four outputs are registered, or decoded straight from the registered state. Each reacts one cycle after the sample that causes it. The line-reset pulse and the serial-mode flag appear after the edge that takes the 50th one. The ready flag appears after the edge that takes the second idle zero. An IDCODE clear appears after the edge that sees the strobe. The bench drives each bit on the falling edge and advances its behavioural model by that same bit. It then compares all four outputs at the next falling edge, half a period after the edge that must have produced them. Scenario checks at chosen points confirm that a switch was accepted or refused.

// File: rtl/lnkw_pkg.sv
package lnkw_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_ARMED,
        ST_MATCH,
        ST_SEAL,
        ST_IDLE,
        ST_READY
    } lnk_state_e;

    localparam int unsigned SEL_W = 16;
    localparam logic [SEL_W-1:0] SEL_CURRENT = 16'h79E7;
    localparam logic [SEL_W-1:0] SEL_LEGACY  = 16'h6DB7;

endpackage

// File: rtl/lnkw_ones_det.sv
module lnkw_ones_det #(
    parameter int unsigned THRESH = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic hit
);
    localparam int unsigned CW = $clog2(THRESH + 1);

    logic [CW-1:0] run_q;

    // saturating count of consecutive ones, cleared by any zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!din) begin
            run_q <= '0;
        end else if (run_q != CW'(THRESH)) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign hit = din && (run_q == CW'(THRESH - 1));

endmodule

// File: rtl/lnkw_sel_window.sv
module lnkw_sel_window #(
    parameter bit ACCEPT_LEGACY = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic start,
    input  logic shift,
    output logic last,
    output logic match
);
    import lnkw_pkg::*;

    localparam int unsigned W  = SEL_W;
    localparam int unsigned CW = $clog2(W + 1);

    logic [W-2:0]  hist_q;
    logic [CW-1:0] fill_q;
    logic [W-1:0]  word_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
            fill_q <= '0;
        end else if (start) begin
            hist_q <= {{(W-2){1'b0}}, din};
            fill_q <= CW'(1);
        end else if (shift) begin
            hist_q <= {hist_q[W-3:0], din};
            fill_q <= fill_q + 1'b1;
        end
    end

    assign word_nx = {hist_q, din};
    assign last    = (fill_q == CW'(W - 1));

    generate
        if (ACCEPT_LEGACY) begin : g_both
            assign match = (word_nx == SEL_CURRENT) || (word_nx == SEL_LEGACY);
        end else begin : g_current
            assign match = (word_nx == SEL_CURRENT);
        end
    endgenerate

endmodule

// File: rtl/link_mode_watcher.sv
module link_mode_watcher #(
    parameter int unsigned RESET_ONES    = 50,
    parameter int unsigned IDLE_MIN      = 2,
    parameter bit          ACCEPT_LEGACY = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic idcode_done,
    output logic lr_pulse,
    output logic sw_mode,
    output logic need_idcode,
    output logic pkt_ready
);
    import lnkw_pkg::*;

    localparam int unsigned ICW = $clog2(IDLE_MIN + 1);

    lnk_state_e    st_q, st_d;
    logic [ICW-1:0] idle_q, idle_d;
    logic          hit, win_last, win_match, win_start, win_shift;
    logic          pulse_q, need_q;

    lnkw_ones_det #(.THRESH(RESET_ONES)) u_ones (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (line_in),
        .hit   (hit)
    );

    lnkw_sel_window #(.ACCEPT_LEGACY(ACCEPT_LEGACY)) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (line_in),
        .start (win_start),
        .shift (win_shift),
        .last  (win_last),
        .match (win_match)
    );

    // next state
    always_comb begin
        st_d      = st_q;
        idle_d    = idle_q;
        win_start = 1'b0;
        win_shift = 1'b0;
        unique case (st_q)
            ST_HUNT: begin
                if (hit) st_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!line_in) begin
                    win_start = 1'b1;
                    st_d      = ST_MATCH;
                end
            end
            ST_MATCH: begin
                win_shift = 1'b1;
                if (win_last) st_d = win_match ? ST_SEAL : ST_HUNT;
            end
            ST_SEAL: begin
                if (hit) begin
                    st_d   = ST_IDLE;
                    idle_d = '0;
                end
            end
            ST_IDLE: begin
                if (line_in) begin
                    idle_d = '0;
                end else if (idle_q == ICW'(IDLE_MIN - 1)) begin
                    st_d   = ST_READY;
                    idle_d = '0;
                end else begin
                    idle_d = idle_q + 1'b1;
                end
            end
            ST_READY: begin
                if (hit) begin
                    st_d   = ST_IDLE;
                    idle_d = '0;
                end
            end
            default: st_d = ST_HUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_HUNT;
            idle_q  <= '0;
            pulse_q <= 1'b0;
            need_q  <= 1'b0;
        end else begin
            st_q    <= st_d;
            idle_q  <= idle_d;
            pulse_q <= hit;
            if (hit && (st_d == ST_IDLE)) begin
                need_q <= 1'b1;
            end else if (idcode_done) begin
                need_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        lr_pulse    = pulse_q;
        need_idcode = need_q;
        sw_mode     = (st_q == ST_IDLE) || (st_q == ST_READY);
        pkt_ready   = (st_q == ST_READY);
    end

endmodule

// File: rtl/link_mode_watcher_chk.sv
module link_mode_watcher_chk (
    input logic clk,
    input logic rst_n,
    input logic line_in,
    input logic idcode_done,
    input logic lr_pulse,
    input logic sw_mode,
    input logic need_idcode,
    input logic pkt_ready
);
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        lr_pulse |=> !lr_pulse); // R2
    AST_PULSE_FROM_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        lr_pulse |-> $past(line_in)); // R2
    AST_SW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        sw_mode |=> sw_mode); // R3
    AST_SW_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_mode) |-> lr_pulse); // R3
    AST_NEED_ON_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_mode && lr_pulse) |-> need_idcode); // R9
    AST_NEED_ONLY_SW: assert property (@(posedge clk) disable iff (!rst_n)
        need_idcode |-> sw_mode); // R9
    AST_READY_IN_SW: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_ready |-> sw_mode); // R10
    AST_READY_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pkt_ready) |-> !$past(line_in)); // R10
    AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        lr_pulse |-> !pkt_ready); // R10
endmodule

bind link_mode_watcher link_mode_watcher_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_in     (line_in),
    .idcode_done (idcode_done),
    .lr_pulse    (lr_pulse),
    .sw_mode     (sw_mode),
    .need_idcode (need_idcode),
    .pkt_ready   (pkt_ready)
);

// File: tb/link_mode_watcher_test.sv
module link_mode_watcher_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_in = 1'b0;
    logic idcode_done = 1'b0;
    logic lr_pulse, sw_mode, need_idcode, pkt_ready;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    // behavioural model state
    int m_ones = 0;
    int m_phase = 0;   // 0 hunt,1 armed,2 capture,3 await reset,4 idle,5 ready
    int m_idle = 0;
    bit m_need = 1'b0;
    bit m_pulse = 1'b0;
    bit m_win[$];

    always #4 clk = ~clk;

    link_mode_watcher uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_in     (line_in),
        .idcode_done (idcode_done),
        .lr_pulse    (lr_pulse),
        .sw_mode     (sw_mode),
        .need_idcode (need_idcode),
        .pkt_ready   (pkt_ready)
    );

    task automatic check(input string req, input logic act, input logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_ones = 0; m_phase = 0; m_idle = 0; m_need = 1'b0; m_pulse = 1'b0;
        m_win.delete();
    endtask

    task automatic model_step(input bit d, input bit done);
        bit hit;
        logic [15:0] w;
        m_ones = d ? m_ones + 1 : 0;
        hit = d && (m_ones == 50);
        m_pulse = hit;
        case (m_phase)
            0: if (hit) m_phase = 1;
            1: if (!d) begin m_win.delete(); m_win.push_back(d); m_phase = 2; end
            2: begin
                m_win.push_back(d);
                if (m_win.size() == 16) begin
                    for (int i = 0; i < 16; i++) w[15-i] = m_win[i];
                    m_phase = (w == 16'h79E7 || w == 16'h6DB7) ? 3 : 0;
                end
            end
            3: if (hit) begin m_phase = 4; m_idle = 0; end
            4: begin
                if (d) m_idle = 0;
                else begin
                    m_idle++;
                    if (m_idle >= 2) begin m_phase = 5; m_idle = 0; end
                end
            end
            default: if (hit) begin m_phase = 4; m_idle = 0; end
        endcase
        if (hit && m_phase == 4) m_need = 1'b1;
        else if (done) m_need = 1'b0;
    endtask

    task automatic tick(input bit d, input bit done);
        line_in = d;
        idcode_done = done;
        model_step(d, done);
        @(posedge clk);
        @(negedge clk);
        check("R2 lr_pulse", lr_pulse, m_pulse);
        check("R3 sw_mode", sw_mode, m_phase >= 4);
        check("R9 need_idcode", need_idcode, m_need);
        check("R10 pkt_ready", pkt_ready, m_phase == 5);
    endtask

    task automatic ones(input int n);
        for (int i = 0; i < n; i++) tick(1'b1, 1'b0);
    endtask

    task automatic zeros(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, 1'b0);
    endtask

    task automatic word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) tick(w[i], 1'b0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        line_in = 1'b0;
        idcode_done = 1'b0;
        model_reset();
        @(negedge clk);
        @(negedge clk);
        check("R1 lr_pulse", lr_pulse, 1'b0);
        check("R1 sw_mode", sw_mode, 1'b0);
        check("R1 need_idcode", need_idcode, 1'b0);
        check("R1 pkt_ready", pkt_ready, 1'b0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL R3 watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R2 short run, R8 word without preceding line reset
        ones(49); zeros(1);
        word(16'h79E7);
        ones(20); zeros(3);
        check("R8 no switch without prior reset", sw_mode, 1'b0);
        ones(100);                       // single pulse in a long run (R2)
        zeros(2);

        // R4 current word, R6 extra ones after line reset ignored
        do_reset();
        ones(56);
        word(16'h79E7);
        ones(55);
        zeros(2);
        check("R4 current word accepted", sw_mode, 1'b1);
        check("R6 capture started at first zero", pkt_ready, 1'b1);
        tick(1'b0, 1'b1);                // clear owed IDCODE (R9)
        tick(1'b0, 1'b1);
        ones(49);
        tick(1'b1, 1'b1);                // reset and clear same cycle (R9)
        zeros(1); ones(1); zeros(1);     // interrupted idle (R10)
        zeros(2);
        tick(1'b0, 1'b1);

        // R5 legacy word
        do_reset();
        ones(50);
        word(16'h6DB7);
        ones(50);
        zeros(2);
        check("R5 legacy word accepted", sw_mode, 1'b1);

        // R7 bad word then a line reset
        do_reset();
        ones(52);
        word(16'h79E6);
        ones(52);
        zeros(4);
        tick(1'b0, 1'b1);
        check("R7 bad word refused", sw_mode, 1'b0);
        ones(30);
        zeros(20);
        ones(60);
        word(16'h6DB7);
        ones(51);
        zeros(1);
        check("R7 ready waits second idle", pkt_ready, 1'b0);
        zeros(1);
        check("R7 full sequence recovers", sw_mode, 1'b1);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule